// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block gathers the interrupt sources of a synchronous serial port whose receive and transmit buffers each hold a parameterised number of entries (eight by default). The port's datapath reports the current fill levels of both buffers, a one-cycle strobe when a complete frame has been received, a one-cycle strobe when software pops the receive buffer, a strobe once per serial bit period and a busy flag. From these the block derives four raw interrupt conditions, masks them with a software-written enable register and drives a single interrupt line.

Two conditions are events: a receive overrun (a frame arrived with the receive buffer already full, so the frame is dropped) and a receive timeout (data has been waiting, unread, for a fixed number of bit periods). Both stay set until software writes one to their clear bit. The other two conditions are pure level comparisons on the buffer fill levels and follow the levels directly. A small register interface writes the enable and clear registers and reads the enable, raw, masked and port status registers through a combinational read path.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: When `frame_done` is high while `rx_level` equals DEPTH, raw bit 0 (overrun) is set from the next cycle on.
- R2: Overrun and timeout stay set until a write to address 3 carries a one in bit 0 (clears overrun) or bit 1 (clears timeout); other bits at address 3 clear nothing, and a set event in the same cycle wins over the clear.
- R3: Raw bit 1 (timeout) is set on the cycle after the 32nd `bit_tick` counted while the receive buffer stays non-empty with no pop and no new frame.
- R4: The timeout count restarts from zero on `rx_pop`, on `frame_done`, and in every cycle in which `rx_level` is zero.
- R5: Raw bit 2 is 1 exactly while `rx_level` is at least DEPTH/2.
- R6: Raw bit 3 is 1 exactly while `tx_level` is at most DEPTH/2, so it reads 1 after reset with an empty transmit buffer.
- R7: Address 0 reads the 4-bit enable register written at address 0; address 1 reads raw bits {transmit, receive, timeout, overrun} in bits 3..0; address 2 reads raw AND enable in the same bit order.
- R8: `irq` is high exactly when any bit read at address 2 is high.
- R9: Address 4 reads status bits: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 4 `busy`; unused addresses read zero.
- R10: After reset the enable register, overrun and timeout are zero.
- R11: `rx_accept` is high exactly when `frame_done` is high and `rx_level` is below DEPTH; a dropped frame leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | LW | Receive buffer fill level, 0..DEPTH |
| tx_level | input | LW | Transmit buffer fill level, 0..DEPTH |
| frame_done | input | 1 | Strobe: a complete frame has been received |
| rx_pop | input | 1 | Strobe: software read of the receive buffer |
| bit_tick | input | 1 | Strobe once per serial bit period |
| busy | input | 1 | Port busy flag, reported in status |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | AW | Register address for read and write |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data, combinational on `bus_addr` |
| rx_accept | output | 1 | Frame may be pushed into the receive buffer |
| irq | output | 1 | Combined interrupt line |

## Verification
A long random run holds the buffer levels for stretches, fires frames, pops and bit ticks at mixed rates and writes enables and clears, so levels that straddle the half thresholds separate the comparison boundaries and writes of clear values with and without the relevant bits separate a real clear from a neighbour's. Directed sequences count bit ticks to the 31st and 32nd, which distinguishes an off-by-one timeout, and insert a pop or an empty stretch mid-count, which shows whether the count restarts or merely pauses. A frame against a full buffer coinciding with a clear write shows which of set and clear wins.

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl #(
  parameter int DEPTH    = 8,
  parameter int TMO_BITS = 32,
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int LW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          frame_done,
  input  logic          rx_pop,
  input  logic          bit_tick,
  input  logic          busy,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_accept,
  output logic          irq
);
  localparam int CW = $clog2(TMO_BITS + 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [CW-1:0] LAST = CW'(TMO_BITS - 1);
  localparam logic [CW-1:0] TOP  = CW'(TMO_BITS);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_RAW  = AW'(1);
  localparam logic [AW-1:0] A_MIS  = AW'(2);
  localparam logic [AW-1:0] A_CLR  = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic [3:0]    mask_q;
  logic          ror_q, rt_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    raw, mis;
  logic          rx_full, rx_empty, restart, ror_set, rt_set, clr_wr;

  assign rx_full  = (rx_level == FULL);
  assign rx_empty = (rx_level == '0);
  assign restart  = rx_pop | frame_done | rx_empty;
  assign ror_set  = frame_done & rx_full;
  assign rt_set   = bit_tick & ~restart & (cnt_q == LAST);
  assign clr_wr   = bus_wr & (bus_addr == A_CLR);

  assign rx_accept = frame_done & ~rx_full;

  assign raw = {tx_level <= HALF, rx_level >= HALF, rt_q, ror_q};
  assign mis = raw & mask_q;
  assign irq = |mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ror_q  <= 1'b0;
      rt_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[3:0];
      if (ror_set) ror_q <= 1'b1;
      else if (clr_wr && bus_wdata[0]) ror_q <= 1'b0;
      if (rt_set) rt_q <= 1'b1;
      else if (clr_wr && bus_wdata[1]) rt_q <= 1'b0;
      if (restart) cnt_q <= '0;
      else if (bit_tick && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK: bus_rdata[3:0] = mask_q;
      A_RAW:  bus_rdata[3:0] = raw;
      A_MIS:  bus_rdata[3:0] = mis;
      A_STAT: bus_rdata[4:0] = {busy, rx_full, ~rx_empty, tx_level != FULL, tx_level == '0};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ssp_irq_ctrl_chk.sv
module ssp_irq_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] rx_level,
  input logic          frame_done,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_accept,
  input logic          irq,
  input logic [3:0]    raw
);
  p_ovr_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_level == LW'(DEPTH)) |=> raw[0]);

  p_ovr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] && !(bus_wr && bus_addr == AW'(3) && bus_wdata[0])) |=> raw[0]);

  p_tmo_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[1] && !(bus_wr && bus_addr == AW'(3) && bus_wdata[1])) |=> raw[1]);

  p_ovr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3) && bus_wdata[0] && !frame_done) |=> !raw[0]);

  p_tmo_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw[1] && rx_level == '0) |=> !raw[1]);

  p_irq_mis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2)) |-> (irq == |bus_rdata[3:0]));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> (frame_done && rx_level != LW'(DEPTH)));
endmodule

bind ssp_irq_ctrl ssp_irq_ctrl_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .frame_done(frame_done),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_accept(rx_accept), .irq(irq), .raw(raw)
);

// File: tb/ssp_irq_ctrl_tb.sv
module ssp_irq_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int LW = 4;
  localparam int TMO = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] rx_level = '0, tx_level = '0;
  logic frame_done = 0, rx_pop = 0, bit_tick = 0, busy = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rx_accept, irq;

  int checks = 0, failures = 0;
  logic m_ror = 0, m_rt = 0;
  logic [3:0] m_mask = '0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  ssp_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .frame_done(frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick), .busy(busy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_accept(rx_accept), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_raw();
    return {tx_level <= 4'(DEPTH/2), rx_level >= 4'(DEPTH/2), m_rt, m_ror};
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [7:0] v = '0;
    case (bus_addr)
      3'd0: v[3:0] = m_mask;
      3'd1: v[3:0] = exp_raw();
      3'd2: v[3:0] = exp_raw() & m_mask;
      3'd4: v[4:0] = {busy, rx_level == 4'(DEPTH), rx_level != 0, tx_level != 4'(DEPTH), tx_level == 0};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_update();
    logic restart, rt_set, clr;
    restart = rx_pop | frame_done | (rx_level == 0);
    rt_set = bit_tick & ~restart & (m_cnt == TMO - 1);
    clr = bus_wr && bus_addr == 3'd3;
    if (frame_done && rx_level == 4'(DEPTH)) m_ror = 1;
    else if (clr && bus_wdata[0]) m_ror = 0;
    if (rt_set) m_rt = 1;
    else if (clr && bus_wdata[1]) m_rt = 0;
    if (restart) m_cnt = 0;
    else if (bit_tick && m_cnt != TMO) m_cnt++;
    if (bus_wr && bus_addr == 3'd0) m_mask = bus_wdata[3:0];
  endtask

  task automatic step(input logic [3:0] rxl, input logic [3:0] txl, input logic fr, input logic pop,
                      input logic tk, input logic bz, input logic we, input logic [2:0] a,
                      input logic [7:0] wd);
    @(negedge clk);
    rx_level = rxl; tx_level = txl; frame_done = fr; rx_pop = pop; bit_tick = tk;
    busy = bz; bus_wr = we; bus_addr = a; bus_wdata = wd;
    #1;
    if (a == 3'd1) begin
      chk("R1 overrun", {7'b0, bus_rdata[0]}, {7'b0, exp_raw()[0]});
      chk("R3 timeout", {7'b0, bus_rdata[1]}, {7'b0, exp_raw()[1]});
      chk("R5 rx half", {7'b0, bus_rdata[2]}, {7'b0, exp_raw()[2]});
      chk("R6 tx half", {7'b0, bus_rdata[3]}, {7'b0, exp_raw()[3]});
    end else if (a == 3'd4) chk("R9 status", bus_rdata, exp_rd());
    else chk("R7 read", bus_rdata, exp_rd());
    chk("R8 irq", {7'b0, irq}, {7'b0, |(exp_raw() & m_mask)});
    chk("R11 accept", {7'b0, rx_accept}, {7'b0, fr && rxl != 4'(DEPTH)});
    @(posedge clk);
    if (rst_n) model_update();
  endtask

  task automatic idle(input logic [3:0] rxl, input logic tk, input int n);
    for (int i = 0; i < n; i++) step(rxl, 4'd0, 0, 0, tk, 0, 0, 3'd1, 8'd0);
  endtask

  task automatic peek_raw(input int bitn, input string req, input logic exp);
    step(rx_level, tx_level, 0, 0, 0, 0, 0, 3'd1, 8'd0);
    chk(req, {7'b0, bus_rdata[bitn]}, {7'b0, exp});
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R10 reset state
    step(0, 0, 0, 0, 0, 0, 0, 3'd0, 0);
    chk("R10 mask", bus_rdata, 8'h00);
    step(0, 0, 0, 0, 0, 0, 0, 3'd1, 0);
    chk("R10 raw", bus_rdata, 8'h08);

    // R3 exact count
    idle(4'd2, 1'b1, 31);
    peek_raw(1, "R3 after 31 ticks", 1'b0);
    idle(4'd2, 1'b1, 1);
    peek_raw(1, "R3 after 32 ticks", 1'b1);
    // R2 clear with wrong bit, then right bit
    step(2, 0, 0, 1, 0, 0, 1, 3'd3, 8'hFD);
    peek_raw(1, "R2 other clear bits", 1'b1);
    step(2, 0, 0, 1, 0, 0, 1, 3'd3, 8'h02);
    peek_raw(1, "R2 timeout cleared", 1'b0);
    // R4 restart on pop
    idle(4'd2, 1'b1, 20);
    step(2, 0, 0, 1, 0, 0, 0, 3'd1, 0);
    idle(4'd2, 1'b1, 20);
    peek_raw(1, "R4 pop restarts", 1'b0);
    idle(4'd2, 1'b1, 12);
    peek_raw(1, "R4 count after pop", 1'b1);
    step(2, 0, 0, 1, 0, 0, 1, 3'd3, 8'h02);
    // R4 empty restarts
    idle(4'd1, 1'b1, 20);
    idle(4'd0, 1'b1, 40);
    idle(4'd1, 1'b1, 31);
    peek_raw(1, "R4 empty restarts", 1'b0);
    // R1 overrun and set-wins
    step(8, 0, 1, 0, 0, 0, 0, 3'd1, 0);
    peek_raw(0, "R1 overrun set", 1'b1);
    step(8, 0, 1, 0, 0, 0, 1, 3'd3, 8'h01);
    peek_raw(0, "R2 set wins over clear", 1'b1);
    step(8, 0, 0, 0, 0, 0, 1, 3'd3, 8'h01);
    peek_raw(0, "R2 overrun cleared", 1'b0);
    // R7 mask boundaries
    step(4, 4, 0, 0, 0, 0, 1, 3'd0, 8'hFF);
    step(4, 4, 0, 0, 0, 0, 0, 3'd2, 0);
    chk("R7 masked half levels", bus_rdata, 8'h0C);
    step(3, 5, 0, 0, 0, 0, 0, 3'd2, 0);
    chk("R7 masked below half", bus_rdata, 8'h00);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] rxl = rx_level, txl = tx_level;
      logic [2:0] a;
      logic [7:0] wd;
      logic we;
      if ($urandom_range(0, 40) == 0) rxl = 4'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 20) == 0) txl = 4'($urandom_range(0, DEPTH));
      we = ($urandom_range(0, 15) == 0);
      a = 3'($urandom_range(0, 5));
      wd = 8'($urandom);
      step(rxl, txl, $urandom_range(0, 60) == 0, $urandom_range(0, 90) == 0,
           $urandom_range(0, 1) == 1, 1'($urandom), we, a, wd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule